// File: doc/BRIEF.md
# Calibration Trigger Sequencer for Orbit Gaps

This block decides, once per slow TURN marker, whether one of three calibration sources (minimum-bias, laser or charge injection) is triggered, and places that trigger inside the long empty-bunch gap of the machine orbit. A host loads an 8-bit-per-entry pattern memory through a plain write port. A pointer advances through the memory by one entry on each TURN pulse. The entry read at that TURN selects the calibration, if any, that is issued in the next gap window.

The gap window is timed from the orbit marker by a bunch-clock counter. It opens a programmable number of clocks after the marker and stays open for a fixed number of slots. Charge injection produces an open pulse and a close pulse a programmable distance apart. The laser path fires its trigger and then waits for an emit acknowledge before it raises the request code. A programmable timeout bounds that wait. A selection that cannot be served before the window closes is dropped and flagged. A busy input blocks new selections but does not stop the pointer.

Top module: `calgap_sequencer`

## Requirements
- R1: Each TURN pulse advances the pattern pointer by one, wrapping from the last entry to entry 0. The entry used for a TURN is the one the pointer held before that advance. After reset the pointer is 0.
- R2: Entry bit 2 selects charge injection, bit 1 selects laser and bit 0 selects minimum-bias. When several of these bits are set, charge injection wins over laser and laser wins over minimum-bias. Bits 7:3 have no effect. An entry with bits 2:0 all zero issues nothing.
- R3: If a selection is pending, the trigger pulse appears in the cycle after the (OFS+1)-th rising edge following the edge that samples orbit high, where OFS is the gap offset. The window covers counter values OFS to OFS+GAP_LEN-1.
- R4: Minimum-bias gives one single-cycle pulse on `mb_trig`. In the same cycle `cal_req` carries 3'b001 for one cycle.
- R5: Charge injection gives two single-cycle pulses on `ci_trig`, SPACE cycles apart, where a spacing of 0 acts as 1. `cal_req` carries 3'b100 in the cycle of the first pulse.
- R6: Laser gives one single-cycle pulse on `laser_trig`. `cal_req` carries 3'b010 for one cycle, starting in the cycle after the rising edge that samples `laser_emit` high.
- R7: If `laser_emit` is not seen within TMO cycles of the laser pulse, `tmo_flag` rises TMO cycles after that pulse and stays high until reset. No request is raised, and the block accepts later selections.
- R8: A selection still pending when the window closes is dropped without any trigger. `miss_flag` rises GAP_LEN cycles after the cycle in which a trigger issued at window opening would have appeared, and stays high until reset.
- R9: A TURN sampled while `busy` is high issues no trigger, but the pointer still advances.
- R10: After reset all trigger outputs, `cal_req` and both flags are low. The gap offset is 3437, the spacing is 40 and the laser timeout is 400.
- R11: `pat_we` writes `pat_wdata` to entry `pat_waddr`. `cfg_we` writes `cfg_wdata` to the gap offset (sel 0), the charge-injection spacing (sel 1) or the laser timeout (sel 2). Sel 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pat_we | input | 1 | Pattern entry write strobe |
| pat_waddr | input | ADDR_W | Pattern entry index |
| pat_wdata | input | ENTRY_W | Pattern entry value |
| cfg_we | input | 1 | Setting write strobe |
| cfg_sel | input | 2 | Setting select: 0 offset, 1 spacing, 2 timeout |
| cfg_wdata | input | CFG_W | Setting value |
| orbit | input | 1 | Orbit marker pulse |
| turn | input | 1 | Slow TURN marker pulse |
| busy | input | 1 | Suppresses new selections |
| laser_emit | input | 1 | Laser emit acknowledge |
| mb_trig | output | 1 | Minimum-bias trigger pulse |
| laser_trig | output | 1 | Laser trigger pulse |
| ci_trig | output | 1 | Charge-injection open/close pulses |
| cal_req | output | 3 | One-hot calibration request code pulse |
| miss_flag | output | 1 | Sticky dropped-selection flag |
| tmo_flag | output | 1 | Sticky laser timeout flag |

## Verification
The bench walks the pointer through every entry of an eight-entry memory and past the wrap. It uses entries with multiple select bits and with only reserved bits, so a wrong priority or a decoder that looks at reserved bits fires the wrong trigger. Trigger cycles are measured against the orbit edge, so an off-by-one in the window start, the pulse spacing or the laser request delay appears as a shifted cycle. A second TURN is placed while a long charge-injection spacing holds the sequencer past the window end, which checks that the pending selection is dropped with a flag rather than fired late. A silent laser checks the timeout and the return to service, and a busy TURN checks that the pointer still moves when the trigger is suppressed.

// File: rtl/calgap_pkg.sv
package calgap_pkg;

   typedef enum logic [1:0] {
      KIND_NONE  = 2'd0,
      KIND_MB    = 2'd1,
      KIND_LASER = 2'd2,
      KIND_CI    = 2'd3
   } cal_kind_t;

   localparam int SEL_BITS = 3;

   // priority: charge injection, then laser, then minimum-bias
   function automatic cal_kind_t pick_kind(input logic [SEL_BITS-1:0] sel);
      if (sel[2])      return KIND_CI;
      else if (sel[1]) return KIND_LASER;
      else if (sel[0]) return KIND_MB;
      return KIND_NONE;
   endfunction

endpackage

// File: rtl/calgap_pattern.sv
module calgap_pattern
   import calgap_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int ENTRY_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [ADDR_W-1:0]  waddr,
   input  logic [ENTRY_W-1:0] wdata,
   input  logic               turn,
   input  logic               busy,
   output logic               sel_vld,
   output cal_kind_t          sel_kind
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (ENTRY_W < SEL_BITS) begin : g_bad_entry
         $error("ENTRY_W must hold the three select bits");
      end
   endgenerate

   logic [ENTRY_W-1:0] mem [DEPTH];
   logic [ADDR_W-1:0]  ptr;
   logic [ENTRY_W-1:0] rd_q;
   logic               vld_q;

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr   <= '0;
         rd_q  <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= turn && !busy;
         if (turn) begin
            rd_q <= mem[ptr];
            ptr  <= ptr + 1'b1;
         end
      end
   end

   assign sel_vld  = vld_q;
   assign sel_kind = pick_kind(rd_q[SEL_BITS-1:0]);

   // R1: pointer steps by one per TURN, wrapping in its width
   p_ptr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      turn |=> (ptr == $past(ptr) + 1'b1));

   // R9: a busy TURN never produces a valid selection
   p_busy_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (turn && busy) |=> !sel_vld);

endmodule

// File: rtl/calgap_window.sv
module calgap_window #(
   parameter int CNT_W   = 16,
   parameter int GAP_LEN = 127
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             orbit,
   input  logic [CNT_W-1:0] ofs,
   output logic             win,
   output logic             close
);
   localparam logic [CNT_W:0] GAP_X = (CNT_W+1)'(GAP_LEN);

   generate
      if (GAP_LEN < 1 || GAP_LEN >= (1 << CNT_W)) begin : g_bad_gap
         $error("GAP_LEN does not fit the orbit counter");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic [CNT_W:0]   end_x;

   // saturating position counter: parked at all-ones until the first marker
   always_ff @(posedge clk) begin
      if (!rst_n)              cnt <= '1;
      else if (orbit)          cnt <= '0;
      else if (cnt != '1)      cnt <= cnt + 1'b1;
   end

   assign end_x = {1'b0, ofs} + GAP_X;
   assign win   = (cnt >= ofs) && ({1'b0, cnt} < end_x);
   assign close = ({1'b0, cnt} == end_x);

endmodule

// File: rtl/calgap_fsm.sv
module calgap_fsm
   import calgap_pkg::*;
#(
   parameter int TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_vld,
   input  cal_kind_t        sel_kind,
   input  logic             win,
   input  logic             close,
   input  logic             laser_emit,
   input  logic [TMR_W-1:0] ci_space,
   input  logic [TMR_W-1:0] laser_tmo,
   output logic             mb_trig,
   output logic             laser_trig,
   output logic             ci_trig,
   output logic [2:0]       cal_req,
   output logic             miss_flag,
   output logic             tmo_flag
);
   typedef enum logic [1:0] {ST_IDLE, ST_CI_GAP, ST_LAS_WAIT} st_t;

   st_t            state;
   cal_kind_t      pend;
   logic [TMR_W-1:0] tmr;
   logic [TMR_W:0]   tmr_nx;
   logic           fire, ci_hit, las_hit;

   assign tmr_nx  = {1'b0, tmr} + (TMR_W+1)'(1);
   assign ci_hit  = tmr_nx >= {1'b0, ci_space};
   assign las_hit = tmr_nx >= {1'b0, laser_tmo};
   assign fire    = (state == ST_IDLE) && win && (pend != KIND_NONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         pend       <= KIND_NONE;
         tmr        <= '0;
         mb_trig    <= 1'b0;
         laser_trig <= 1'b0;
         ci_trig    <= 1'b0;
         cal_req    <= 3'b000;
         miss_flag  <= 1'b0;
         tmo_flag   <= 1'b0;
      end else begin
         mb_trig    <= 1'b0;
         laser_trig <= 1'b0;
         ci_trig    <= 1'b0;
         cal_req    <= 3'b000;
         case (state)
            ST_IDLE: if (fire) begin
               tmr <= '0;
               case (pend)
                  KIND_MB: begin
                     mb_trig <= 1'b1;
                     cal_req <= 3'b001;
                  end
                  KIND_LASER: begin
                     laser_trig <= 1'b1;
                     state      <= ST_LAS_WAIT;
                  end
                  KIND_CI: begin
                     ci_trig <= 1'b1;
                     cal_req <= 3'b100;
                     state   <= ST_CI_GAP;
                  end
                  default: ;
               endcase
            end
            ST_CI_GAP: begin
               if (ci_hit) begin
                  ci_trig <= 1'b1;
                  state   <= ST_IDLE;
               end else begin
                  tmr <= tmr_nx[TMR_W-1:0];
               end
            end
            ST_LAS_WAIT: begin
               if (laser_emit) begin
                  cal_req <= 3'b010;
                  state   <= ST_IDLE;
               end else if (las_hit) begin
                  tmo_flag <= 1'b1;
                  state    <= ST_IDLE;
               end else begin
                  tmr <= tmr_nx[TMR_W-1:0];
               end
            end
            default: state <= ST_IDLE;
         endcase

         if (fire) begin
            pend <= KIND_NONE;
         end else if (close && pend != KIND_NONE) begin
            pend      <= KIND_NONE;
            miss_flag <= 1'b1;
         end
         if (sel_vld && sel_kind != KIND_NONE) pend <= sel_kind;
      end
   end

   // R2: at most one trigger line active in any cycle
   p_trig_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mb_trig, laser_trig, ci_trig}));

   // R3: minimum-bias and laser pulses follow a cycle inside the window
   p_fire_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mb_trig || laser_trig) |-> $past(win));

   // R5: the charge-injection request code comes with an injection pulse
   p_req_ci_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_req == 3'b100) |-> ci_trig);

   // R7: timeout flag is sticky
   p_tmo_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_flag |=> tmo_flag);

   // R8: miss flag is sticky
   p_miss_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      miss_flag |=> miss_flag);

endmodule

// File: rtl/calgap_sequencer.sv
module calgap_sequencer
   import calgap_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int ENTRY_W = 8,
   parameter int CNT_W   = 16,
   parameter int TMR_W   = 16,
   parameter int GAP_LEN = 127,
   parameter int OFS_RST = 3437,
   parameter int SPC_RST = 40,
   parameter int TMO_RST = 400,
   localparam int CFG_W  = (CNT_W > TMR_W) ? CNT_W : TMR_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pat_we,
   input  logic [ADDR_W-1:0]  pat_waddr,
   input  logic [ENTRY_W-1:0] pat_wdata,
   input  logic               cfg_we,
   input  logic [1:0]         cfg_sel,
   input  logic [CFG_W-1:0]   cfg_wdata,
   input  logic               orbit,
   input  logic               turn,
   input  logic               busy,
   input  logic               laser_emit,
   output logic               mb_trig,
   output logic               laser_trig,
   output logic               ci_trig,
   output logic [2:0]         cal_req,
   output logic               miss_flag,
   output logic               tmo_flag
);
   generate
      if (OFS_RST >= (1 << CNT_W)) begin : g_bad_ofs
         $error("OFS_RST does not fit CNT_W");
      end
      if (SPC_RST >= (1 << TMR_W) || TMO_RST >= (1 << TMR_W)) begin : g_bad_tmr
         $error("timer reset values do not fit TMR_W");
      end
   endgenerate

   logic [CNT_W-1:0] ofs_q;
   logic [TMR_W-1:0] spc_q, tmo_q;
   logic             sel_vld, win, close;
   cal_kind_t        sel_kind;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ofs_q <= CNT_W'(OFS_RST);
         spc_q <= TMR_W'(SPC_RST);
         tmo_q <= TMR_W'(TMO_RST);
      end else if (cfg_we) begin
         case (cfg_sel)
            2'd0:    ofs_q <= cfg_wdata[CNT_W-1:0];
            2'd1:    spc_q <= cfg_wdata[TMR_W-1:0];
            2'd2:    tmo_q <= cfg_wdata[TMR_W-1:0];
            default: ;
         endcase
      end
   end

   calgap_pattern #(.ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W)) u_pattern (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (pat_we),
      .waddr    (pat_waddr),
      .wdata    (pat_wdata),
      .turn     (turn),
      .busy     (busy),
      .sel_vld  (sel_vld),
      .sel_kind (sel_kind)
   );

   calgap_window #(.CNT_W(CNT_W), .GAP_LEN(GAP_LEN)) u_window (
      .clk   (clk),
      .rst_n (rst_n),
      .orbit (orbit),
      .ofs   (ofs_q),
      .win   (win),
      .close (close)
   );

   calgap_fsm #(.TMR_W(TMR_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_vld    (sel_vld),
      .sel_kind   (sel_kind),
      .win        (win),
      .close      (close),
      .laser_emit (laser_emit),
      .ci_space   (spc_q),
      .laser_tmo  (tmo_q),
      .mb_trig    (mb_trig),
      .laser_trig (laser_trig),
      .ci_trig    (ci_trig),
      .cal_req    (cal_req),
      .miss_flag  (miss_flag),
      .tmo_flag   (tmo_flag)
   );

endmodule

// File: tb/calgap_sequencer_tb.sv
module calgap_sequencer_tb;
   localparam int AW = 3;
   localparam int GL = 8;
   localparam int NE = 1 << AW;

   logic clk = 1'b0, rst_n = 1'b0;
   logic pat_we = 0, cfg_we = 0, orbit = 0, turn = 0, busy = 0, laser_emit = 0;
   logic [AW-1:0] pat_waddr = '0;
   logic [7:0]    pat_wdata = '0;
   logic [1:0]    cfg_sel = '0;
   logic [15:0]   cfg_wdata = '0;
   logic mb_trig, laser_trig, ci_trig, miss_flag, tmo_flag;
   logic [2:0] cal_req;

   calgap_sequencer #(.ADDR_W(AW), .GAP_LEN(GL)) u_dut (
      .clk(clk), .rst_n(rst_n), .pat_we(pat_we), .pat_waddr(pat_waddr),
      .pat_wdata(pat_wdata), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .orbit(orbit), .turn(turn), .busy(busy),
      .laser_emit(laser_emit), .mb_trig(mb_trig), .laser_trig(laser_trig),
      .ci_trig(ci_trig), .cal_req(cal_req), .miss_flag(miss_flag),
      .tmo_flag(tmo_flag)
   );

   always #4 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_run = 0, n_fail = 0;
   int gofs = 3437, gspc = 40, gtmo = 400;
   int ptr = 0;
   logic [7:0] emem [NE];
   int ork, mb_n, las_n, ci_n, req_n, mb_at, las_at, ci_at0, ci_at1, req_at, miss_at, tmo_at;
   logic [2:0] req_val;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic pat_wr(input int a, input logic [7:0] d);
      @(negedge clk); pat_we = 1; pat_waddr = AW'(a); pat_wdata = d;
      @(negedge clk); pat_we = 0;
      emem[a] = d;
   endtask

   task automatic cfg_wr(input int s, input int d);
      @(negedge clk); cfg_we = 1; cfg_sel = 2'(s); cfg_wdata = 16'(d);
      @(negedge clk); cfg_we = 0;
      if (s == 0) gofs = d; else if (s == 1) gspc = d; else if (s == 2) gtmo = d;
   endtask

   // one TURN, then one orbit marker, then watch; xt >= 0 adds a TURN at cycle P+xt
   task automatic run_slot(input bit b, input bit resp, input int len, input int xt);
      int p;
      @(negedge clk); turn = 1; busy = b;
      @(negedge clk); turn = 0; busy = 0;
      ptr = (ptr + 1) % NE;
      @(negedge clk);
      @(negedge clk); orbit = 1; ork = cyc + 1;
      mb_n = 0; las_n = 0; ci_n = 0; req_n = 0; req_val = 0;
      mb_at = -1; las_at = -1; ci_at0 = -1; ci_at1 = -1; req_at = -1;
      miss_at = -1; tmo_at = -1;
      p = ork + gofs + 1;
      @(negedge clk); orbit = 0;
      repeat (len) begin
         if (mb_trig) begin mb_n++; mb_at = cyc; end
         if (laser_trig) begin las_n++; las_at = cyc; end
         if (ci_trig) begin
            if (ci_n == 0) ci_at0 = cyc; else if (ci_n == 1) ci_at1 = cyc;
            ci_n++;
         end
         if (cal_req != 0) begin req_n++; req_val = cal_req; req_at = cyc; end
         if (miss_flag && miss_at < 0) miss_at = cyc;
         if (tmo_flag && tmo_at < 0) tmo_at = cyc;
         laser_emit = resp && laser_trig;
         if (xt >= 0 && cyc == p + xt) begin
            turn = 1; ptr = (ptr + 1) % NE;
         end else begin
            turn = 0;
         end
         @(negedge clk);
      end
      laser_emit = 0; turn = 0;
   endtask

   // expected outcome from the entry encoding (R2)
   task automatic check_slot(input logic [7:0] e, input bit b, input string tag);
      int p;
      p = ork + gofs + 1;
      if (b || e[2:0] == 3'b000) begin
         chk(mb_n + las_n + ci_n + req_n == 0, {tag, " R2/R9 nothing issued"},
             mb_n + las_n + ci_n + req_n, 0);
      end else if (e[2]) begin
         chk(ci_n == 2, {tag, " R2/R5 ci pulse count"}, ci_n, 2);
         chk(ci_at0 == p, {tag, " R3/R5 ci open cycle"}, ci_at0, p);
         chk(ci_at1 == p + ((gspc == 0) ? 1 : gspc), {tag, " R5 ci close cycle"},
             ci_at1, p + ((gspc == 0) ? 1 : gspc));
         chk(req_val == 3'b100 && req_at == p, {tag, " R5 ci request"}, req_at, p);
         chk(mb_n + las_n == 0, {tag, " R2 only ci"}, mb_n + las_n, 0);
      end else if (e[1]) begin
         chk(las_n == 1 && las_at == p, {tag, " R2/R3/R6 laser cycle"}, las_at, p);
         chk(req_n == 1 && req_val == 3'b010 && req_at == p + 1, {tag, " R6 laser request"},
             req_at, p + 1);
         chk(mb_n + ci_n == 0, {tag, " R2 only laser"}, mb_n + ci_n, 0);
      end else begin
         chk(mb_n == 1 && mb_at == p, {tag, " R2/R3/R4 mb cycle"}, mb_at, p);
         chk(req_n == 1 && req_val == 3'b001 && req_at == p, {tag, " R4 mb request"},
             req_at, p);
         chk(las_n + ci_n == 0, {tag, " R2 only mb"}, las_n + ci_n, 0);
      end
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R10: reset state
      chk({mb_trig, laser_trig, ci_trig, cal_req, miss_flag, tmo_flag} == 8'd0,
          "R10 outputs after reset", {mb_trig, laser_trig, ci_trig, cal_req, miss_flag, tmo_flag}, 0);

      // R10/R11: default offset 3437 with a pattern write at entry 0
      pat_wr(0, 8'h01);
      run_slot(0, 0, 3437 + 20, -1);
      check_slot(8'h01, 0, "default offset R10/R11");

      // R11: select 3 writes nothing, then real settings
      cfg_wr(3, 2);
      cfg_wr(0, 6);
      cfg_wr(1, 3);
      cfg_wr(2, 5);
      gofs = 6;
      pat_wr(1, 8'h02); pat_wr(2, 8'h04); pat_wr(3, 8'h00); pat_wr(4, 8'h07);
      pat_wr(5, 8'h03); pat_wr(6, 8'hF9); pat_wr(7, 8'hF8); pat_wr(0, 8'h05);

      // R1/R2: sweep over all entries and past the wrap; slot 8 is busy (R9)
      for (int s = 0; s < 11; s++) begin
         automatic int idx = ptr;
         automatic bit b = (s == 7);
         run_slot(b, 1, 40, -1);
         check_slot(emem[idx], b, $sformatf("R1 sweep entry %0d", idx));
      end
      // pointer now at entry 4; make it charge injection with long spacing
      cfg_wr(1, 12);
      pat_wr(4, 8'h04);
      pat_wr(5, 8'h01);

      // R8: second TURN pends while the close pulse is still far away
      run_slot(0, 1, 40, 1);
      chk(ci_n == 2 && ci_at1 == ork + gofs + 1 + 12, "R5 long spacing close", ci_at1, ork + gofs + 13);
      chk(mb_n == 0, "R8 dropped selection not fired", mb_n, 0);
      chk(miss_at == ork + gofs + 1 + GL, "R8 miss flag cycle", miss_at, ork + gofs + 1 + GL);
      chk(tmo_flag == 0, "R7 no timeout yet", tmo_flag, 0);

      // R7: laser without emit
      pat_wr(6, 8'h02);
      run_slot(0, 0, 40, -1);
      chk(las_n == 1 && las_at == ork + gofs + 1, "R7 laser fired", las_at, ork + gofs + 1);
      chk(tmo_at == ork + gofs + 1 + 5, "R7 timeout cycle", tmo_at, ork + gofs + 6);
      chk(req_n == 0, "R7 no request on timeout", req_n, 0);

      // R7: back in service afterwards (entry 7 is reserved-only, then entry 0)
      run_slot(0, 1, 40, -1);
      check_slot(emem[7], 0, "R7 after timeout entry 7");
      pat_wr(0, 8'h01);
      run_slot(0, 1, 40, -1);
      check_slot(8'h01, 0, "R7 after timeout entry 0");
      chk(miss_flag == 1 && tmo_flag == 1, "R7/R8 flags stay set", {miss_flag, tmo_flag}, 3);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule